// File: doc/BRIEF.md
# Shift-Addressable Random-Access Scan Array

This block keeps a grid of scan cells laid out as rows and columns. In functional operation every cell is a plain D flip-flop that loads its functional input on each clock. In test operation the block does not decode a row address. Instead, a one-hot row pointer selects exactly one row, and that pointer moves to the next row in a fixed circular order whenever the advance input is asserted. Each column has its own scan-in and scan-out lane, so one access writes a whole row and reads its old contents in the same cycle.

A test access writes the column stimulus into the row the pointer selects. On the next cycle the row's previous contents show on the registered column outputs. Each column output passes through its own enable gate before it reaches a downstream compactor. With the serial option set, each column takes its stimulus from the old value of the column on its left, and column 0 takes its own scan-in lane. The selected row then shifts one column per access, like a short serial chain. A capture command loads functional data into every cell while test operation stays selected.

Top module: `sars_top`

## Requirements
- R1: While reset is asserted on a clock edge, the row pointer selects row 0 (`row_sel` = 1), every cell clears to 0 and `scan_out` clears to 0.
- R2: `row_sel` always has exactly one bit set.
- R3: With `test_mode`=1 and `row_adv`=1, the selected row moves from row r to row r+1, and from the last row back to row 0. With `row_adv`=0 or `test_mode`=0, the pointer is unchanged.
- R4: With `test_mode`=0, every cell loads `func_d` on each clock, with cell (row r, column c) at bit r*COLS+c of `func_d` and `cell_q`. `scan_en`, `capture` and the scan lanes have no effect on the cells.
- R5: An access (`test_mode`=1, `capture`=0, `scan_en`=1) with `serial`=0 writes `scan_in[c]` into column c of the selected row.
- R6: After an access, `scan_out[c]` on the next cycle equals the selected row's column c value from before the write, gated by `obs_en[c]`. Without an access, `scan_out` holds its value.
- R7: An access leaves every unselected row unchanged.
- R8: An access with `serial`=1 writes `scan_in[0]` into column 0 and the old value of column c-1 into column c for c>0, all within the selected row.
- R9: When `obs_en[c]`=0, the access drives `scan_out[c]` to 0 whatever the cell holds.
- R10: With `test_mode`=1 and `capture`=1, every cell loads `func_d`, and capture takes priority over `scan_en`. With `test_mode`=1 and neither `capture` nor `scan_en` set, all cells hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode | input | 1 | 1 selects test operation, 0 selects functional operation |
| row_adv | input | 1 | Moves the row pointer to the next row (test operation only) |
| scan_en | input | 1 | Row access: write the lanes and read the old row |
| capture | input | 1 | Loads functional data into all cells in test operation |
| serial | input | 1 | Chains each column from the column on its left |
| scan_in | input | COLS | Per-column stimulus lanes |
| obs_en | input | COLS | Per-column observation enables |
| func_d | input | ROWS*COLS | Functional data for every cell |
| cell_q | output | ROWS*COLS | Cell contents |
| row_sel | output | ROWS | One-hot row pointer |
| scan_out | output | COLS | Registered, gated old contents of the accessed row |

## Verification
If the row pointer is corrupted, the next access writes the wrong row. The error shows on `cell_q` and on `row_sel` in the cycle after that access. If a column is routed wrongly or a gate is broken, the wrong bits reach `scan_out` one cycle after the access. A wrong serial chaining shows up the same way, after the first serial access. An update leaking into other rows changes their `cell_q` bits on the same edge, so the check in the following cycle catches it.

// File: rtl/sars_pkg.sv
package sars_pkg;
  typedef enum logic [1:0] {
    OP_FUNC = 2'd0,
    OP_CAPT = 2'd1,
    OP_ACC  = 2'd2,
    OP_HOLD = 2'd3
  } cell_op_e;
endpackage

// File: rtl/sars_row_ring.sv
module sars_row_ring #(
  parameter int ROWS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  output logic [ROWS-1:0] row_sel
);
  localparam logic [ROWS-1:0] FIRST_ROW = {{(ROWS-1){1'b0}}, 1'b1};

  logic [ROWS-1:0] ring_q;

  always_ff @(posedge clk) begin
    if (rst)      ring_q <= FIRST_ROW;
    else if (adv) ring_q <= {ring_q[ROWS-2:0], ring_q[ROWS-1]};
  end

  assign row_sel = ring_q;

  assert_row_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(row_sel) == 1);

  assert_row_rotate_R3: assert property (@(posedge clk) disable iff (rst)
    adv |=> row_sel == {$past(row_sel[ROWS-2:0]), $past(row_sel[ROWS-1])});

  assert_row_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(row_sel));
endmodule

// File: rtl/sars_col_route.sv
module sars_col_route #(
  parameter int COLS = 4
) (
  input  logic [COLS-1:0] old_row,
  input  logic [COLS-1:0] scan_in,
  input  logic            serial,
  input  logic [COLS-1:0] obs_en,
  output logic [COLS-1:0] wr_row,
  output logic [COLS-1:0] obs_row
);
  for (genvar gc = 0; gc < COLS; gc++) begin : g_col
    if (gc == 0) begin : g_head
      assign wr_row[gc] = scan_in[gc];
    end else begin : g_link
      assign wr_row[gc] = serial ? old_row[gc-1] : scan_in[gc];
    end
    assign obs_row[gc] = old_row[gc] & obs_en[gc];
  end
endmodule

// File: rtl/sars_cell_array.sv
module sars_cell_array
  import sars_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cell_op_e             op,
  input  logic [ROWS-1:0]      row_sel,
  input  logic [ROWS*COLS-1:0] func_d,
  input  logic [COLS-1:0]      wr_row,
  output logic [ROWS*COLS-1:0] cells,
  output logic [COLS-1:0]      rd_row
);
  logic [COLS-1:0] row_q [ROWS];

  for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        row_q[gr] <= '0;
      end else begin
        case (op)
          OP_FUNC, OP_CAPT: row_q[gr] <= func_d[gr*COLS +: COLS];
          OP_ACC:           if (row_sel[gr]) row_q[gr] <= wr_row;
          default:          row_q[gr] <= row_q[gr];
        endcase
      end
    end

    assign cells[gr*COLS +: COLS] = row_q[gr];

    assert_unselected_stable_R7: assert property (@(posedge clk) disable iff (rst)
      (op == OP_ACC && !row_sel[gr]) |=> $stable(cells[gr*COLS +: COLS]));

    assert_func_load_R4: assert property (@(posedge clk) disable iff (rst)
      (op == OP_FUNC) |=> cells[gr*COLS +: COLS] == $past(func_d[gr*COLS +: COLS]));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (op == OP_HOLD) |=> $stable(cells[gr*COLS +: COLS]));
  end

  always_comb begin
    rd_row = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_sel[r]) rd_row = rd_row | row_q[r];
    end
  end
endmodule

// File: rtl/sars_top.sv
module sars_top
  import sars_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 test_mode,
  input  logic                 row_adv,
  input  logic                 scan_en,
  input  logic                 capture,
  input  logic                 serial,
  input  logic [COLS-1:0]      scan_in,
  input  logic [COLS-1:0]      obs_en,
  input  logic [ROWS*COLS-1:0] func_d,
  output logic [ROWS*COLS-1:0] cell_q,
  output logic [ROWS-1:0]      row_sel,
  output logic [COLS-1:0]      scan_out
);
  localparam int CELLS = ROWS * COLS;

  cell_op_e        op;
  logic            access;
  logic [COLS-1:0] old_row;
  logic [COLS-1:0] wr_row;
  logic [COLS-1:0] obs_row;
  logic [CELLS-1:0] cells;
  logic [COLS-1:0] so_q;

  always_comb begin
    if (!test_mode)   op = OP_FUNC;
    else if (capture) op = OP_CAPT;
    else if (scan_en) op = OP_ACC;
    else              op = OP_HOLD;
  end

  assign access = (op == OP_ACC);

  sars_row_ring #(.ROWS(ROWS)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .adv     (test_mode & row_adv),
    .row_sel (row_sel)
  );

  sars_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .row_sel (row_sel),
    .func_d  (func_d),
    .wr_row  (wr_row),
    .cells   (cells),
    .rd_row  (old_row)
  );

  sars_col_route #(.COLS(COLS)) u_route (
    .old_row (old_row),
    .scan_in (scan_in),
    .serial  (serial),
    .obs_en  (obs_en),
    .wr_row  (wr_row),
    .obs_row (obs_row)
  );

  always_ff @(posedge clk) begin
    if (rst)         so_q <= '0;
    else if (access) so_q <= obs_row;
  end

  assign scan_out = so_q;
  assign cell_q   = cells;

  assert_scan_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !access |=> $stable(scan_out));

  for (genvar gc = 0; gc < COLS; gc++) begin : g_chk
    assert_masked_col_R9: assert property (@(posedge clk) disable iff (rst)
      (access && !obs_en[gc]) |=> !scan_out[gc]);
  end
endmodule

// File: tb/tb_sars_top.sv
`timescale 1ns/1ps
module tb_sars_top;
  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int CELLS = ROWS * COLS;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             test_mode = 1'b0, row_adv = 1'b0, scan_en = 1'b0;
  logic             capture = 1'b0, serial = 1'b0;
  logic [COLS-1:0]  scan_in = '0, obs_en = '0;
  logic [CELLS-1:0] func_d = '0;
  logic [CELLS-1:0] cell_q;
  logic [ROWS-1:0]  row_sel;
  logic [COLS-1:0]  scan_out;

  int checks = 0;
  int errors = 0;

  logic [CELLS-1:0] m_cells;
  int               m_row;
  logic [COLS-1:0]  m_so;

  always #2 clk = ~clk;

  sars_top #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rst(rst), .test_mode(test_mode), .row_adv(row_adv),
    .scan_en(scan_en), .capture(capture), .serial(serial),
    .scan_in(scan_in), .obs_en(obs_en), .func_d(func_d),
    .cell_q(cell_q), .row_sel(row_sel), .scan_out(scan_out)
  );

  function automatic logic [COLS-1:0] f_write(input logic [COLS-1:0] old,
                                              input logic [COLS-1:0] sin,
                                              input logic ser);
    logic [COLS-1:0] n;
    for (int c = 0; c < COLS; c++) n[c] = (ser && c > 0) ? old[c-1] : sin[c];
    return n;
  endfunction

  function automatic int f_next_row(input int r);
    return (r == ROWS-1) ? 0 : r + 1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic tm, input logic sen, input logic adv,
                      input logic cap, input logic ser,
                      input logic [COLS-1:0] sin, input logic [COLS-1:0] oen,
                      input logic [CELLS-1:0] fd);
    logic [CELLS-1:0] selmask;
    logic [COLS-1:0]  old;
    bit               acc;
    @(negedge clk);
    test_mode = tm; scan_en = sen; row_adv = adv; capture = cap;
    serial = ser; scan_in = sin; obs_en = oen; func_d = fd;
    @(posedge clk);
    acc     = tm && !cap && sen;
    selmask = '0;
    selmask[m_row*COLS +: COLS] = '1;
    old     = m_cells[m_row*COLS +: COLS];
    if (!tm || cap) m_cells = fd;
    else if (sen) begin
      m_cells[m_row*COLS +: COLS] = f_write(old, sin, ser);
      m_so = old & oen;
    end
    if (tm && adv) m_row = f_next_row(m_row);
    #1;
    chk("R3 row pointer", 64'(row_sel), 64'(1 << m_row));
    chk("R2 one-hot", 64'($countones(row_sel)), 64'd1);
    if (acc) begin
      chk(ser ? "R8 serial row write" : "R5 parallel row write",
          64'(cell_q & selmask), 64'(m_cells & selmask));
      chk("R7 unselected rows", 64'(cell_q & ~selmask), 64'(m_cells & ~selmask));
    end else begin
      chk(!tm ? "R4 functional load" : "R10 capture/hold", 64'(cell_q), 64'(m_cells));
    end
    chk((oen != '1) ? "R9 gated scan_out" : "R6 scan_out", 64'(scan_out), 64'(m_so));
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_cells = '0; m_row = 0; m_so = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset row_sel", 64'(row_sel), 64'd1);
    chk("R1 reset cells", 64'(cell_q), 64'd0);
    chk("R1 reset scan_out", 64'(scan_out), 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R3: full wrap of the pointer, then advance ignored in functional mode
    for (int i = 0; i < ROWS + 1; i++) step(1, 0, 1, 0, 0, '0, '1, '0);
    step(0, 1, 1, 0, 0, 4'hF, '1, 16'hA5C3);
    step(1, 0, 0, 0, 0, 4'h0, '1, 16'h0000);

    // R5/R6: fill each row in parallel, then read back
    for (int r = 0; r < ROWS; r++) step(1, 1, 1, 0, 0, 4'(r * 3 + 5), '1, '0);
    for (int r = 0; r < ROWS; r++) step(1, 1, 1, 0, 0, 4'h0, '1, '0);

    // R8: serial shifting within one row
    step(1, 1, 0, 0, 1, 4'h1, '1, '0);
    step(1, 1, 0, 0, 1, 4'h0, '1, '0);
    step(1, 1, 0, 0, 1, 4'h1, '1, '0);
    step(1, 1, 0, 0, 1, 4'h0, '1, '0);

    // R9: masked columns
    step(1, 1, 0, 0, 0, 4'hF, 4'b0000, '0);
    step(1, 1, 0, 0, 0, 4'h0, 4'b0101, '0);

    // R10: capture beats access; R4: scan lanes ignored in functional mode
    step(1, 1, 0, 1, 0, 4'hF, '1, 16'h1234);
    step(1, 0, 0, 0, 0, 4'hF, '1, 16'hFFFF);
    step(0, 1, 0, 1, 1, 4'hF, '1, 16'h8001);

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 8) != 0, ($urandom % 3) != 0, $urandom % 2,
           ($urandom % 6) == 0, $urandom % 2, 4'($urandom), 4'($urandom),
           16'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule